// File: doc/BRIEF.md
# Four-Note Sawtooth Melody Sequencer

This block plays a short, fixed melody of four notes as a rising sawtooth on an 8-bit sample bus that feeds a resistor-ladder DAC. It sits idle with the sample held at zero until a one-cycle start pulse arrives. It then walks through four note states in a fixed order and returns to idle on its own after the last one. A new start pulse plays the melody again.

Each note has its own step interval. This is a count of clock cycles between sample increments, so it sets the pitch. A single note length, shared by all four notes, sets how long each note sounds. With a 25 MHz clock the default step counts are 1184, 1117, 1184 and 1329. These follow clock / (256 × f) − 1 for tones of about 82.4 Hz, 87.3 Hz, 82.4 Hz and 73.4 Hz. The default note length is 12,500,000 cycles, which is half a second. The machine keeps a current-state register and a next-state decode. Reset is synchronous.

Top module: `saw_melody_seq`

## Requirements
- R1: A synchronous reset puts the block in idle: `playing` is 0 and `sample` is 0 at the first sampling point after the reset edge.
- R2: When `start` is 1 at a clock edge while the block is idle, the first note begins at that edge: `playing` goes to 1 and `sample` is 0 in the first cycle of the note.
- R3: The notes play in the fixed order note 0, note 1, note 2, note 3. Each note lasts exactly NOTE_CYCLES cycles, so the melody occupies 4 × NOTE_CYCLES cycles. The step counts default to 1184, 1117, 1184 and 1329.
- R4: Within note k, whose step count is P_k, the sample rises by one every P_k + 1 cycles. At cycle offset o into the note (o = 0 in the note's first cycle), the sample equals the note's starting value plus floor(o / (P_k + 1)).
- R5: The sample is not cleared between notes. Each note starts from the value the previous note left. The sample is 8 bits and wraps from 255 to 0.
- R6: After the last cycle of note 3 the block returns to idle. `playing` becomes 0, and `sample` is 0 and stays 0 for as long as the block is idle.
- R7: A `start` pulse that arrives while a melody is playing has no effect. The melody's sample sequence and its end time are unchanged.
- R8: The block can be started again after a melody ends. When `start` is held high, the next melody begins at the edge that follows the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request; acted on only while idle |
| sample | output | 8 | Sawtooth sample to the DAC (SAMPLE_W bits) |
| playing | output | 1 | High while any of the four notes is sounding |

## Verification
The assertions assume that `start` and `rst` are synchronous to `clk` and are stable around the rising edge. They also assume every step count fits the counter width derived from the largest one. The bench changes both inputs only on the falling edge. It uses small step counts (1, 2, 1, 3) and a 400-cycle note, so the sample wraps during the second note and each melody finishes quickly. Random start pulses and rare resets land in idle, in the middle of notes, on note boundaries and on the final cycle. This lets every transition the assertions guard happen many times.

// File: rtl/melody_pkg.sv
package melody_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_NOTE0 = 3'd1,
    ST_NOTE1 = 3'd2,
    ST_NOTE2 = 3'd3,
    ST_NOTE3 = 3'd4
  } mel_state_t;

  localparam int NUM_NOTES = 4;

  // Index of the note a tone state plays (0 for idle).
  function automatic logic [1:0] note_of(input mel_state_t s);
    case (s)
      ST_NOTE1: note_of = 2'd1;
      ST_NOTE2: note_of = 2'd2;
      ST_NOTE3: note_of = 2'd3;
      default:  note_of = 2'd0;
    endcase
  endfunction

  // State that follows a tone state once its duration runs out.
  function automatic mel_state_t follow(input mel_state_t s);
    case (s)
      ST_NOTE0: follow = ST_NOTE1;
      ST_NOTE1: follow = ST_NOTE2;
      ST_NOTE2: follow = ST_NOTE3;
      default:  follow = ST_IDLE;
    endcase
  endfunction

  // Largest of four step counts, used to size the step counter.
  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/mel_step_div.sv
module mel_step_div #(
  parameter int STEP_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              reload_now,
  input  logic [STEP_W-1:0] reload_val,
  input  logic [STEP_W-1:0] period,
  output logic              tick
);

  logic [STEP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (reload_now) begin
      cnt_q <= reload_val;
    end else if (cnt_q == '0) begin
      cnt_q <= period;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/mel_note_timer.sv
module mel_note_timer #(
  parameter int NOTE_CYCLES = 12_500_000,
  localparam int DUR_W = (NOTE_CYCLES > 2) ? $clog2(NOTE_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic note_end
);

  localparam logic [DUR_W-1:0] LAST = DUR_W'(NOTE_CYCLES - 1);

  logic [DUR_W-1:0] dur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dur_q <= '0;
    end else if (!run || dur_q == '0) begin
      dur_q <= LAST;
    end else begin
      dur_q <= dur_q - 1'b1;
    end
  end

  assign note_end = run && (dur_q == '0);

endmodule

// File: rtl/mel_sample_acc.sv
module mel_sample_acc #(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                bump,
  output logic [SAMPLE_W-1:0] sample
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sample <= '0;
    end else if (bump) begin
      sample <= sample + 1'b1;
    end
  end

endmodule

// File: rtl/saw_melody_seq.sv
module saw_melody_seq
  import melody_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int NOTE_CYCLES = 12_500_000,
  parameter int STEP_0      = 1184,
  parameter int STEP_1      = 1117,
  parameter int STEP_2      = 1184,
  parameter int STEP_3      = 1329
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  output logic [SAMPLE_W-1:0] sample,
  output logic                playing
);

  localparam int STEP_MAX = max4(STEP_0, STEP_1, STEP_2, STEP_3);
  localparam int STEP_W   = (STEP_MAX > 1) ? $clog2(STEP_MAX + 1) : 1;

  function automatic logic [STEP_W-1:0] step_of(input logic [1:0] idx);
    case (idx)
      2'd0:    step_of = STEP_W'(STEP_0);
      2'd1:    step_of = STEP_W'(STEP_1);
      2'd2:    step_of = STEP_W'(STEP_2);
      default: step_of = STEP_W'(STEP_3);
    endcase
  endfunction

  mel_state_t st_q, st_d;
  logic [1:0] cur_idx;
  logic       note_end;
  logic       step_tick;
  logic       melody_done;
  logic       reload_now;
  logic [STEP_W-1:0] reload_val;
  logic [STEP_W-1:0] period;

  assign playing     = (st_q != ST_IDLE);
  assign cur_idx     = note_of(st_q);
  assign melody_done = note_end && (st_q == ST_NOTE3);

  // Next-state decode
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_NOTE0;
      default: if (note_end) st_d = follow(st_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  // Step divider reload: note 0's count while idle, next note's at a boundary
  assign reload_now = !playing || note_end;
  assign reload_val = playing ? step_of(cur_idx + 2'd1) : step_of(2'd0);
  assign period     = step_of(cur_idx);

  mel_step_div #(.STEP_W(STEP_W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .run        (playing),
    .reload_now (reload_now),
    .reload_val (reload_val),
    .period     (period),
    .tick       (step_tick)
  );

  mel_note_timer #(.NOTE_CYCLES(NOTE_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (playing),
    .note_end (note_end)
  );

  mel_sample_acc #(.SAMPLE_W(SAMPLE_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .clear  (st_d == ST_IDLE),
    .bump   (step_tick),
    .sample (sample)
  );

  // R2: a start seen in idle opens note 0 at the next edge
  a_r2_start_enters: assert property (@(posedge clk) disable iff (rst)
    (!playing && start) |=> (st_q == ST_NOTE0));

  // R3: each note boundary advances to the next note in order
  a_r3_note_order: assert property (@(posedge clk) disable iff (rst)
    (note_end && st_q != ST_NOTE3) |=> (cur_idx == $past(cur_idx) + 2'd1));

  // R4: a divider tick moves the sample up by exactly one
  a_r4_step_bump: assert property (@(posedge clk) disable iff (rst)
    (step_tick && !melody_done) |=> (sample == $past(sample) + SAMPLE_W'(1)));

  // R4: without a tick the sample holds
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (playing && !step_tick && !melody_done) |=> $stable(sample));

  // R6: the end of note 3 lands in idle with a zero sample
  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    melody_done |=> (!playing && sample == '0));

  // R6: idle always shows zero
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !playing |-> (sample == '0));

  // R7: start during a note does not disturb the state
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (playing && start && !note_end) |=> $stable(st_q));

endmodule

// File: tb/sim_saw_melody_seq.sv
module sim_saw_melody_seq;

  localparam int L  = 400;
  localparam int P0 = 1, P1 = 2, P2 = 1, P3 = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] sample;
  logic       playing;

  int n_tests = 0;
  int n_fail  = 0;

  // Bench model state
  bit m_idle = 1'b1;
  int m_e    = 0;
  bit m_prev_done = 1'b0;

  always #10 clk = ~clk;

  saw_melody_seq #(
    .SAMPLE_W(8), .NOTE_CYCLES(L),
    .STEP_0(P0), .STEP_1(P1), .STEP_2(P2), .STEP_3(P3)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .sample(sample), .playing(playing)
  );

  function automatic int step_p(input int k);
    case (k)
      0: return P0;
      1: return P1;
      2: return P2;
      default: return P3;
    endcase
  endfunction

  // Expected sample e cycles after the melody began (R4, R5)
  function automatic logic [7:0] exp_sample(input int e);
    int k, o, acc;
    k = e / L;
    o = e % L;
    acc = 0;
    for (int j = 0; j < k; j++) acc += L / (step_p(j) + 1);
    acc += o / (step_p(k) + 1);
    return 8'(acc % 256);
  endfunction

  task automatic check(input string req, input logic [7:0] act_s, input logic act_p,
                       input logic [7:0] exp_s, input logic exp_p);
    n_tests++;
    if (act_s !== exp_s || act_p !== exp_p) begin
      n_fail++;
      $display("FAIL %s: sample=%0d playing=%0b expected sample=%0d playing=%0b (e=%0d)",
               req, act_s, act_p, exp_s, exp_p, m_e);
    end
  endtask

  // Drive one cycle, advance the model at the edge, check at the falling edge
  task automatic cycle(input bit r, input bit s);
    string tag;
    bit was_playing;
    rst = r;
    start = s;
    was_playing = !m_idle;
    @(posedge clk);
    if (r) begin
      m_idle = 1'b1;
      m_prev_done = 1'b0;
    end else if (m_idle) begin
      if (s) begin
        m_idle = 1'b0;
        m_e = 0;
      end
    end else begin
      m_e++;
      if (m_e == 4 * L) begin
        m_idle = 1'b1;
        m_prev_done = 1'b1;
      end
    end
    @(negedge clk);
    if (r)                              tag = "R1";
    else if (m_idle)                    tag = "R6";
    else if (m_e == 0 && m_prev_done)   tag = "R8";
    else if (m_e == 0)                  tag = "R2";
    else if (was_playing && s)          tag = "R7";
    else if (m_e % L == 0)              tag = "R3";
    else if (exp_sample(m_e) < exp_sample(m_e - 1)) tag = "R5";
    else                                tag = "R4";
    if (m_idle) check(tag, sample, playing, 8'd0, 1'b0);
    else        check(tag, sample, playing, exp_sample(m_e), 1'b1);
    if (!m_idle && m_e == 0) m_prev_done = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    repeat (3) cycle(1'b1, 1'b0);               // R1 reset state
    repeat (5) cycle(1'b0, 1'b0);               // R6 idle holds zero
    cycle(1'b0, 1'b1);                          // R2 single start pulse
    repeat (4 * L + 10) cycle(1'b0, 1'b0);      // R3 R4 R5 R6 full melody
    repeat (8 * L + 20) cycle(1'b0, 1'b1);      // R7 held start, R8 restart
    repeat (20) cycle(1'b0, 1'b0);
    for (int i = 0; i < 12000; i++) begin
      bit r, s;
      r = ($urandom_range(0, 2999) == 0);
      s = ($urandom_range(0, 39) == 0);
      cycle(r, s);
    end
    cycle(1'b1, 1'b0);                          // R1 reset mid-run
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected end before 150000 cycles");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule